// File: doc/BRIEF.md
# Dual-View Doorbell Mailbox

This block lets one agent ring doorbells for another. A configurable number of channels each hold a flag word. The sending agent raises flags and the receiving agent lowers them. Each agent reaches the block through its own register window, on its own simple request/response port. A flag can be raised only from the sender window and lowered only from the receiver window, so neither side can undo the other's action by mistake.

The receiver gets one interrupt line per channel. Each line stays high while that channel has any flag up. The sender window also has a capability word that gives the channel count, and a wake handshake. The sender first writes a request bit. That bit drives a wake line toward the receiver's power controller. The sender then polls a ready bit until the receiver's power controller confirms it is awake. Clearing the request lets the receiver sleep again; the block never forces the receiver to sleep.

Both ports take one request per cycle and never apply back-pressure. A read returns its data with a response strobe exactly one cycle after the request, and it shows the register contents as they were before any write in that same cycle. Writes produce no response. The response data is meaningful only while the response strobe is high.

Top module: `dbell_mbox`

## Requirements
- R1: A sender write to offset 0x0C of channel window c (window base c*0x20) ORs the written word into channel c's flag word, effective on the next clock edge.
- R2: A receiver write to offset 0x08 of channel window c clears every flag bit of channel c that is written as one, and leaves the other bits unchanged.
- R3: When a sender set and a receiver clear hit the same bit of the same channel in one cycle, the bit ends up set.
- R4: A read of offset 0x00 of a channel window returns that channel's flag word in both views. Every read produces its response strobe and data in the cycle after the request, showing the value from before any write in that request's cycle.
- R5: A sender write to offset 0x08 and a receiver write to offset 0x0C have no effect on any flag word.
- R6: Interrupt bit c is high exactly when channel c's flag word is nonzero. It falls in the cycle after the write that clears the last bit.
- R7: In the sender view, offset 0xF80 is read-only and reads as the channel count (3 by default).
- R8: In the sender view, bit 0 of offset 0xF88 is the wake request. It is writable and readable, and the wake output equals it from the cycle after the write.
- R9: In the sender view, offset 0xF8C is read-only. Its bit 0 reads as 1 only when the wake request is set and the receiver-awake input is high; otherwise it reads as 0.
- R10: In the receiver view, offsets 0xF80, 0xF88 and 0xF8C read as zero, and writes to them change nothing.
- R11: Reads of any other offset, including windows of channels that do not exist and misaligned offsets, return zero. Writes to them change nothing.
- R12: After reset all flag words, interrupts, the wake request and both response strobes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| snd_req_valid | input | 1 | Sender request present, always accepted |
| snd_req_write | input | 1 | Sender request is a write (1) or read (0) |
| snd_req_addr | input | AW (12) | Sender byte offset |
| snd_req_wdata | input | DW (32) | Sender write data |
| snd_rsp_valid | output | 1 | Sender read data valid, one cycle after the read |
| snd_rsp_rdata | output | DW (32) | Sender read data |
| rcv_req_valid | input | 1 | Receiver request present, always accepted |
| rcv_req_write | input | 1 | Receiver request is a write (1) or read (0) |
| rcv_req_addr | input | AW (12) | Receiver byte offset |
| rcv_req_wdata | input | DW (32) | Receiver write data |
| rcv_rsp_valid | output | 1 | Receiver read data valid, one cycle after the read |
| rcv_rsp_rdata | output | DW (32) | Receiver read data |
| rcv_irq | output | NUM_CH (3) | Per-channel interrupt, high while flags are up |
| rcv_wake | output | 1 | Wake request toward the receiver's power control |
| rcv_awake | input | 1 | Receiver reports that it is awake |

## Verification
Two events can land in the same cycle: a sender set and a receiver clear on the same channel, and a read of a flag word while the other port writes it. The bench provokes both on purpose. It drives both ports in one cycle with overlapping masks, then checks that the overlapping bits stay set and that the read shows the pre-write word. A randomized phase then mixes sets, clears, reads, wake writes and changes on the awake input on both ports. Every cycle, the interrupts, the wake line and both responses are compared against a behavioural model.

// File: rtl/dbm_pkg.sv
package dbm_pkg;
  // Channel windows are 32 bytes apart; low bits select the register.
  localparam int          WIN_SHIFT = 5;
  localparam logic [4:0]  OFS_STAT  = 5'h00;
  localparam logic [4:0]  OFS_CLR   = 5'h08;
  localparam logic [4:0]  OFS_SET   = 5'h0C;
  // Sender-only block registers.
  localparam logic [11:0] ADDR_CAP  = 12'hF80;
  localparam logic [11:0] ADDR_WREQ = 12'hF88;
  localparam logic [11:0] ADDR_WRDY = 12'hF8C;
endpackage

// File: rtl/dbm_decode.sv
module dbm_decode #(
  parameter int AW        = 12,
  parameter int NUM_CH    = 3,
  parameter bit IS_SENDER = 1'b1
) (
  input  logic              valid,
  input  logic              write,
  input  logic [AW-1:0]     addr,
  output logic [NUM_CH-1:0] stat_rd,
  output logic [NUM_CH-1:0] op_wr,
  output logic              cap_rd,
  output logic              wreq_rd,
  output logic              wrdy_rd,
  output logic              wreq_wr
);
  import dbm_pkg::*;

  localparam int         WW     = AW - WIN_SHIFT;
  localparam logic [4:0] OP_OFS = IS_SENDER ? OFS_SET : OFS_CLR;

  logic          rd, wr;
  logic [WW-1:0] win;
  logic [4:0]    ofs;

  assign rd  = valid & ~write;
  assign wr  = valid & write;
  assign win = addr[AW-1:WIN_SHIFT];
  assign ofs = addr[WIN_SHIFT-1:0];

  // One decoder per channel window; windows above NUM_CH fall through.
  for (genvar c = 0; c < NUM_CH; c++) begin : g_win
    assign stat_rd[c] = rd && (win == WW'(c)) && (ofs == OFS_STAT);
    assign op_wr[c]   = wr && (win == WW'(c)) && (ofs == OP_OFS);
  end

  if (IS_SENDER) begin : g_snd
    assign cap_rd  = rd && (addr == AW'(ADDR_CAP));
    assign wreq_rd = rd && (addr == AW'(ADDR_WREQ));
    assign wrdy_rd = rd && (addr == AW'(ADDR_WRDY));
    assign wreq_wr = wr && (addr == AW'(ADDR_WREQ));
  end else begin : g_rcv
    assign cap_rd  = 1'b0;
    assign wreq_rd = 1'b0;
    assign wrdy_rd = 1'b0;
    assign wreq_wr = 1'b0;
  end
endmodule

// File: rtl/dbm_chan.sv
module dbm_chan #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [DW-1:0] set_bits,
  input  logic          clr_en,
  input  logic [DW-1:0] clr_bits,
  output logic [DW-1:0] status,
  output logic          irq
);
  logic [DW-1:0] set_m, clr_m;

  assign set_m = set_en ? set_bits : '0;
  assign clr_m = clr_en ? clr_bits : '0;

  // Clear first, then OR the set mask: a collision keeps the bit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               status <= '0;
    else if (set_en || clr_en) status <= (status & ~clr_m) | set_m;
  end

  assign irq = |status;

  // R1
  set_bits_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ((status & $past(set_bits)) == $past(set_bits)));

  // R2
  clr_bits_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> ((status & $past(clr_bits)) == '0));

  // R5
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && !clr_en) |=> $stable(status));

  // R6
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en && ((status & ~clr_bits) == '0)) |=> !irq);
endmodule

// File: rtl/dbm_wake.sv
module dbm_wake (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  input  logic awake_i,
  output logic req_q,
  output logic rdy_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     req_q <= 1'b0;
    else if (wr_en) req_q <= wr_bit;
  end

  // Ready is only meaningful while this side is asking.
  assign rdy_o = req_q & awake_i;

  // R8
  wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(req_q));

  // R8
  wake_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (req_q == $past(wr_bit)));
endmodule

// File: rtl/dbm_rdmux.sv
module dbm_rdmux #(
  parameter int DW     = 32,
  parameter int NUM_CH = 3
) (
  input  logic [NUM_CH-1:0] stat_rd,
  input  logic [DW-1:0]     stat [NUM_CH],
  input  logic              cap_rd,
  input  logic              wreq_rd,
  input  logic              wrdy_rd,
  input  logic              wake_req,
  input  logic              wake_rdy,
  output logic [DW-1:0]     rdata
);
  // AND-OR mux: unselected and unmapped offsets contribute zero.
  always_comb begin
    rdata = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (stat_rd[c]) rdata |= stat[c];
    if (cap_rd)  rdata |= DW'(NUM_CH);
    if (wreq_rd) rdata |= DW'(wake_req);
    if (wrdy_rd) rdata |= DW'(wake_rdy);
  end
endmodule

// File: rtl/dbell_mbox.sv
module dbell_mbox #(
  parameter int NUM_CH = 3,
  parameter int DW     = 32,
  parameter int AW     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snd_req_valid,
  input  logic              snd_req_write,
  input  logic [AW-1:0]     snd_req_addr,
  input  logic [DW-1:0]     snd_req_wdata,
  output logic              snd_rsp_valid,
  output logic [DW-1:0]     snd_rsp_rdata,
  input  logic              rcv_req_valid,
  input  logic              rcv_req_write,
  input  logic [AW-1:0]     rcv_req_addr,
  input  logic [DW-1:0]     rcv_req_wdata,
  output logic              rcv_rsp_valid,
  output logic [DW-1:0]     rcv_rsp_rdata,
  output logic [NUM_CH-1:0] rcv_irq,
  output logic              rcv_wake,
  input  logic              rcv_awake
);
  logic [NUM_CH-1:0] s_stat_rd, s_set_wr, r_stat_rd, r_clr_wr;
  logic s_cap_rd, s_wreq_rd, s_wrdy_rd, s_wreq_wr;
  logic r_cap_rd, r_wreq_rd, r_wrdy_rd, r_wreq_wr;
  logic [DW-1:0] stat [NUM_CH];
  logic [DW-1:0] s_rd_d, r_rd_d;
  logic wake_q, wake_rdy;

  dbm_decode #(.AW(AW), .NUM_CH(NUM_CH), .IS_SENDER(1'b1)) u_snd_dec (
    .valid(snd_req_valid), .write(snd_req_write), .addr(snd_req_addr),
    .stat_rd(s_stat_rd), .op_wr(s_set_wr), .cap_rd(s_cap_rd),
    .wreq_rd(s_wreq_rd), .wrdy_rd(s_wrdy_rd), .wreq_wr(s_wreq_wr));

  dbm_decode #(.AW(AW), .NUM_CH(NUM_CH), .IS_SENDER(1'b0)) u_rcv_dec (
    .valid(rcv_req_valid), .write(rcv_req_write), .addr(rcv_req_addr),
    .stat_rd(r_stat_rd), .op_wr(r_clr_wr), .cap_rd(r_cap_rd),
    .wreq_rd(r_wreq_rd), .wrdy_rd(r_wrdy_rd), .wreq_wr(r_wreq_wr));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dbm_chan #(.DW(DW)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .set_en(s_set_wr[c]), .set_bits(snd_req_wdata),
      .clr_en(r_clr_wr[c]), .clr_bits(rcv_req_wdata),
      .status(stat[c]), .irq(rcv_irq[c]));
  end

  // The receiver decoder ties its wake strobe low; OR keeps one write path.
  dbm_wake u_wake (
    .clk(clk), .rst_n(rst_n),
    .wr_en(s_wreq_wr | r_wreq_wr), .wr_bit(snd_req_wdata[0]),
    .awake_i(rcv_awake), .req_q(wake_q), .rdy_o(wake_rdy));

  assign rcv_wake = wake_q;

  dbm_rdmux #(.DW(DW), .NUM_CH(NUM_CH)) u_snd_mux (
    .stat_rd(s_stat_rd), .stat(stat), .cap_rd(s_cap_rd),
    .wreq_rd(s_wreq_rd), .wrdy_rd(s_wrdy_rd),
    .wake_req(wake_q), .wake_rdy(wake_rdy), .rdata(s_rd_d));

  dbm_rdmux #(.DW(DW), .NUM_CH(NUM_CH)) u_rcv_mux (
    .stat_rd(r_stat_rd), .stat(stat), .cap_rd(r_cap_rd),
    .wreq_rd(r_wreq_rd), .wrdy_rd(r_wrdy_rd),
    .wake_req(wake_q), .wake_rdy(wake_rdy), .rdata(r_rd_d));

  // One-cycle read response on each port.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snd_rsp_valid <= 1'b0;
      snd_rsp_rdata <= '0;
      rcv_rsp_valid <= 1'b0;
      rcv_rsp_rdata <= '0;
    end else begin
      snd_rsp_valid <= snd_req_valid & ~snd_req_write;
      snd_rsp_rdata <= s_rd_d;
      rcv_rsp_valid <= rcv_req_valid & ~rcv_req_write;
      rcv_rsp_rdata <= r_rd_d;
    end
  end

  // R4
  snd_rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snd_rsp_valid |-> $past(snd_req_valid && !snd_req_write));

  // R4
  rcv_rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rcv_rsp_valid |-> $past(rcv_req_valid && !rcv_req_write));

  // R10
  rcv_no_wake_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(snd_req_valid && snd_req_write)) |=> $stable(rcv_wake));
endmodule

// File: tb/dbell_mbox_test.sv
module dbell_mbox_test;
  localparam int NCH = 3;
  localparam int DW  = 32;
  localparam int AW  = 12;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic sv, sw, rv, rw, awake;
  logic [AW-1:0] sa, ra;
  logic [DW-1:0] sd, rd;
  logic srv, rrv, wake;
  logic [DW-1:0] srd, rrd;
  logic [NCH-1:0] irq;

  dbell_mbox #(.NUM_CH(NCH), .DW(DW), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .snd_req_valid(sv), .snd_req_write(sw), .snd_req_addr(sa), .snd_req_wdata(sd),
    .snd_rsp_valid(srv), .snd_rsp_rdata(srd),
    .rcv_req_valid(rv), .rcv_req_write(rw), .rcv_req_addr(ra), .rcv_req_wdata(rd),
    .rcv_rsp_valid(rrv), .rcv_rsp_rdata(rrd),
    .rcv_irq(irq), .rcv_wake(wake), .rcv_awake(awake));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [DW-1:0] m_stat [NCH];
  logic          m_wreq;

  function automatic logic [DW-1:0] snd_view(input logic [AW-1:0] a);
    if (a[4:0] == 5'h00 && int'(a[AW-1:5]) < NCH) return m_stat[a[AW-1:5]];
    if (a == 12'hF80) return DW'(NCH);
    if (a == 12'hF88) return DW'(m_wreq);
    if (a == 12'hF8C) return DW'(m_wreq & awake);
    return '0;
  endfunction

  function automatic logic [DW-1:0] rcv_view(input logic [AW-1:0] a);
    if (a[4:0] == 5'h00 && int'(a[AW-1:5]) < NCH) return m_stat[a[AW-1:5]];
    return '0;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // One clock: sample after the edge, advance the model, compare.
  task automatic step(input string tag);
    logic e_srv, e_rrv;
    logic [DW-1:0] e_srd, e_rrd;
    logic [NCH-1:0] e_irq;
    @(posedge clk);
    #1;
    e_srv = sv & ~sw;
    e_rrv = rv & ~rw;
    e_srd = snd_view(sa);
    e_rrd = rcv_view(ra);
    for (int c = 0; c < NCH; c++) begin
      logic [DW-1:0] s_m, c_m;
      s_m = (sv && sw && sa[4:0] == 5'h0C && int'(sa[AW-1:5]) == c) ? sd : '0;
      c_m = (rv && rw && ra[4:0] == 5'h08 && int'(ra[AW-1:5]) == c) ? rd : '0;
      m_stat[c] = (m_stat[c] & ~c_m) | s_m;
    end
    if (sv && sw && sa == 12'hF88) m_wreq = sd[0];
    for (int c = 0; c < NCH; c++) e_irq[c] = (m_stat[c] != '0);
    chk(tag, "irq", DW'(irq), DW'(e_irq));
    chk(tag, "wake", DW'(wake), DW'(m_wreq));
    chk(tag, "snd_rsp_valid", DW'(srv), DW'(e_srv));
    chk(tag, "rcv_rsp_valid", DW'(rrv), DW'(e_rrv));
    if (e_srv) chk(tag, "snd_rsp_rdata", srd, e_srd);
    if (e_rrv) chk(tag, "rcv_rsp_rdata", rrd, e_rrd);
    sv = 0; sw = 0; rv = 0; rw = 0;
  endtask

  task automatic both(input bit s_v, input bit s_w, input logic [AW-1:0] s_a,
                      input logic [DW-1:0] s_d, input bit r_v, input bit r_w,
                      input logic [AW-1:0] r_a, input logic [DW-1:0] r_d,
                      input string tag);
    sv = s_v; sw = s_w; sa = s_a; sd = s_d;
    rv = r_v; rw = r_w; ra = r_a; rd = r_d;
    step(tag);
  endtask

  task automatic snd_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    both(1, 1, a, d, 0, 0, '0, '0, tag);
  endtask
  task automatic snd_rd(input logic [AW-1:0] a, input string tag);
    both(1, 0, a, '0, 0, 0, '0, '0, tag);
  endtask
  task automatic rcv_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    both(0, 0, '0, '0, 1, 1, a, d, tag);
  endtask
  task automatic rcv_rd(input logic [AW-1:0] a, input string tag);
    both(0, 0, '0, '0, 1, 0, a, '0, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    sv = 0; sw = 0; sa = '0; sd = '0;
    rv = 0; rw = 0; ra = '0; rd = '0;
    awake = 0;
    m_wreq = 0;
    for (int c = 0; c < NCH; c++) m_stat[c] = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step("R12");
    step("R12");

    snd_wr(12'h00C, 32'h0000_00F0, "R1");
    snd_wr(12'h00C, 32'h0000_0001, "R1");
    snd_rd(12'h000, "R4");
    rcv_rd(12'h000, "R4");
    rcv_wr(12'h008, 32'h0000_0010, "R2");
    rcv_rd(12'h000, "R2");

    both(1, 1, 12'h02C, 32'h3, 1, 1, 12'h028, 32'h3, "R3");
    both(1, 1, 12'h02C, 32'h1, 1, 1, 12'h028, 32'h3, "R3");
    rcv_rd(12'h020, "R3");

    snd_wr(12'h028, 32'hFFFF_FFFF, "R5");
    rcv_wr(12'h04C, 32'h0000_00AA, "R5");
    snd_rd(12'h020, "R5");
    rcv_rd(12'h040, "R5");

    rcv_wr(12'h008, 32'hFFFF_FFFF, "R6");
    step("R6");
    rcv_wr(12'h028, 32'h0000_0001, "R6");

    both(1, 1, 12'h04C, 32'h5, 1, 0, 12'h040, '0, "R4");
    rcv_rd(12'h040, "R4");

    snd_rd(12'hF80, "R7");
    snd_wr(12'hF80, 32'h55, "R7");
    snd_rd(12'hF80, "R7");

    snd_wr(12'hF88, 32'h1, "R8");
    snd_rd(12'hF88, "R8");
    awake = 0;
    snd_rd(12'hF8C, "R9");
    awake = 1;
    snd_rd(12'hF8C, "R9");
    snd_wr(12'hF88, 32'h0, "R8");
    snd_rd(12'hF8C, "R9");
    snd_wr(12'hF8C, 32'h1, "R9");
    snd_rd(12'hF88, "R9");

    rcv_rd(12'hF80, "R10");
    rcv_rd(12'hF88, "R10");
    rcv_rd(12'hF8C, "R10");
    rcv_wr(12'hF88, 32'h1, "R10");
    step("R10");

    snd_wr(12'h06C, 32'h1, "R11");
    snd_rd(12'h060, "R11");
    snd_rd(12'h004, "R11");
    snd_rd(12'h010, "R11");
    snd_wr(12'h00D, 32'h1, "R11");
    snd_rd(12'h000, "R11");
    snd_rd(12'hF84, "R11");
    rcv_rd(12'h068, "R11");

    for (int i = 0; i < 600; i++) begin
      logic [AW-1:0] s_a, r_a;
      int ch;
      ch  = $urandom_range(0, NCH);
      s_a = AW'(ch * 32 + ($urandom_range(0, 1) ? 12 : 0));
      if ($urandom_range(0, 7) == 0) s_a = $urandom_range(0, 1) ? 12'hF88 : 12'hF8C;
      ch  = $urandom_range(0, NCH);
      r_a = AW'(ch * 32 + ($urandom_range(0, 1) ? 8 : 0));
      awake = 1'($urandom_range(0, 1));
      both(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), s_a,
           DW'($urandom_range(0, 255)) << $urandom_range(0, 24),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), r_a,
           DW'($urandom_range(0, 255)) << $urandom_range(0, 24), "R3");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule